// File: doc/BRIEF.md
# CPU Status Word Register

This block keeps the eight-bit status word of a small 8-bit processor core. It holds the condition flags from arithmetic, the global interrupt enable, the break marker and the direct-page select. Arithmetic flags are worked out locally from the ALU operands, so carry, half-carry, signed overflow, zero and negative come from one consistent evaluation. Other sources write single flags through dedicated strobes: data transfers, shift and rotate carries, the bit-test operation, and the single-flag instructions.

Interrupt acceptance clears the enable flag and a software break sets the break marker. A whole-byte write restores a saved status word. A separate query port turns an 8-bit direct-page offset into a full 16-bit address, and the select flag chooses the page. Each update takes effect at the next rising clock edge. The page address is combinational.

Top module: `cpu_status_word`

## Requirements
- R1: After the asynchronous reset, or one cycle after a `psw_clear` pulse, `psw` is 0x00. The packed byte is ordered, from bit 7 down to bit 0: N, V, G, B, H, I, Z, C.
- R2: An `arith_en` cycle computes a + b + cin, or a + ~b + cin when `arith_sub` is 1. C takes the carry out of bit 7, so for subtraction 1 means no borrow. Z is set when the 8-bit result is zero. N takes result bit 7.
- R3: On an `arith_en` cycle, V is set exactly when the signed result lies outside -128..+127.
- R4: On an `arith_en` cycle, H is set on a carry from bit 3 into bit 4. For subtraction this means no borrow from bit 4.
- R5: `op_ei` sets I and `op_di` clears it, with `op_di` winning when both are asserted. `int_accept` clears I even when `op_ei` is asserted in the same cycle.
- R6: `op_clrv` clears H and V together and overrides every other source of those two flags. No input sets V except arithmetic, bit test and restore.
- R7: `bit_test` copies `bit_mem[6]` into V and `bit_mem[7]` into N. It has no effect on the other flags.
- R8: `op_setg` sets G and `op_clrg` clears it, with `op_clrg` winning. `dp_addr` equals {7'b0, G, dp_offset} in the same cycle.
- R9: `brk_exec` sets B. B stays set through later flag activity until a restore or a clear.
- R10: `restore_we` loads `restore_data` into the whole byte and overrides every strobe in that cycle. `psw_clear` overrides `restore_we`.
- R11: `data_en` writes N from `data_val[7]` and Z from (`data_val` == 0) only. `carry_we` writes C only. A cycle with no strobe leaves `psw` unchanged.
- R12: For a shared flag, the sources rank from highest to lowest as follows. For N and Z: bit test, then arithmetic, then data transfer. For C: arithmetic, then carry write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psw_clear | input | 1 | Synchronous clear of the status byte |
| restore_we | input | 1 | Whole-byte load strobe |
| restore_data | input | 8 | Byte to load |
| int_accept | input | 1 | Interrupt accepted, clears I |
| brk_exec | input | 1 | Software break executed, sets B |
| op_ei | input | 1 | Set interrupt enable |
| op_di | input | 1 | Clear interrupt enable |
| op_setg | input | 1 | Set direct-page select |
| op_clrg | input | 1 | Clear direct-page select |
| op_clrv | input | 1 | Clear H and V |
| bit_test | input | 1 | Bit-test strobe |
| bit_mem | input | 8 | Memory byte under test |
| arith_en | input | 1 | Arithmetic flag update strobe |
| arith_sub | input | 1 | 1 = subtract, 0 = add |
| arith_cin | input | 1 | Carry in |
| arith_a | input | 8 | First operand |
| arith_b | input | 8 | Second operand |
| data_en | input | 1 | Transfer result strobe (N, Z) |
| data_val | input | 8 | Transferred value |
| carry_we | input | 1 | Carry write strobe |
| carry_val | input | 1 | Carry value to write |
| dp_offset | input | 8 | Direct-page offset to map |
| dp_addr | output | 16 | Mapped direct-page address |
| psw | output | 8 | Packed status byte |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Overflow |
| flag_g | output | 1 | Direct-page select |
| flag_b | output | 1 | Break |
| flag_h | output | 1 | Half carry |
| flag_i | output | 1 | Interrupt enable |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |

## Verification
Every flag result lands one rising edge after its strobe. The bench drives inputs on the falling edge, releases them just after the next rising edge, and compares `psw` on the following falling edge. `dp_addr` has no register, so it is checked half a cycle after G or the offset changes, with no edge in between. Clear, restore, interrupt-accept and strobe events that meet in one cycle are applied together in a single cycle, so the ranking between them is what gets checked.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;

  // Field order is the packed byte order, bit 7 first.
  typedef struct packed {
    logic n;
    logic v;
    logic g;
    logic b;
    logic h;
    logic i;
    logic z;
    logic c;
  } psw_t;

  typedef struct packed {
    logic c;
    logic h;
    logic v;
    logic n;
    logic z;
  } arith_flags_t;
endpackage

// File: rtl/psw_arith_flags.sv
module psw_arith_flags
  import psw_pkg::*;
(
  input  logic              sub,
  input  logic              cin,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output arith_flags_t      flags
);
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full_sum;
  logic [NIB_W:0]    low_sum;

  always_comb begin
    b_eff    = sub ? ~b : b;
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    low_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    flags.c  = full_sum[DATA_W];
    flags.h  = low_sum[NIB_W];
    flags.v  = (a[DATA_W-1] == b_eff[DATA_W-1]) && (full_sum[DATA_W-1] != a[DATA_W-1]);
    flags.n  = full_sum[DATA_W-1];
    flags.z  = (full_sum[DATA_W-1:0] == '0);
  end
endmodule

// File: rtl/psw_flag_ctrl.sv
module psw_flag_ctrl
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  psw_t              cur,
  input  logic              psw_clear,
  input  logic              restore_we,
  input  logic [DATA_W-1:0] restore_data,
  input  logic              int_accept,
  input  logic              brk_exec,
  input  logic              op_ei,
  input  logic              op_di,
  input  logic              op_setg,
  input  logic              op_clrg,
  input  logic              op_clrv,
  input  logic              bit_test,
  input  logic [DATA_W-1:0] bit_mem,
  input  logic              arith_en,
  input  arith_flags_t      ar,
  input  logic              data_en,
  input  logic [DATA_W-1:0] data_val,
  input  logic              carry_we,
  input  logic              carry_val,
  output psw_t              nxt,
  output logic              upd
);
  always_comb begin
    upd = psw_clear | restore_we | int_accept | brk_exec | op_ei | op_di |
          op_setg | op_clrg | op_clrv | bit_test | arith_en | data_en | carry_we;
    nxt = cur;
    if (psw_clear) begin
      nxt = '0;
    end else if (restore_we) begin
      nxt = restore_data;
    end else begin
      if (arith_en)      nxt.c = ar.c;
      else if (carry_we) nxt.c = carry_val;

      if (arith_en)      nxt.z = ar.z;
      else if (data_en)  nxt.z = (data_val == '0);

      if (bit_test)      nxt.n = bit_mem[DATA_W-1];
      else if (arith_en) nxt.n = ar.n;
      else if (data_en)  nxt.n = data_val[DATA_W-1];

      if (op_clrv)       nxt.v = 1'b0;
      else if (bit_test) nxt.v = bit_mem[DATA_W-2];
      else if (arith_en) nxt.v = ar.v;

      if (op_clrv)       nxt.h = 1'b0;
      else if (arith_en) nxt.h = ar.h;

      if (int_accept || op_di) nxt.i = 1'b0;
      else if (op_ei)          nxt.i = 1'b1;

      if (op_clrg)       nxt.g = 1'b0;
      else if (op_setg)  nxt.g = 1'b1;

      if (brk_exec)      nxt.b = 1'b1;
    end
  end

  // R6: clear of H and V beats arithmetic in the same cycle
  a_r6_clrv_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (op_clrv && !psw_clear && !restore_we) |-> (!nxt.h && !nxt.v));

  // R5: interrupt acceptance beats enable
  a_r5_intack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (int_accept && !psw_clear && !restore_we) |-> !nxt.i);
endmodule

// File: rtl/psw_page_map.sv
module psw_page_map #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              page_sel,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - OFF_W;

  always_comb begin
    addr = {{(HI_W-1){1'b0}}, page_sel, offset};
  end
endmodule

// File: rtl/cpu_status_word.sv
module cpu_status_word
  import psw_pkg::*;
#(
  parameter int DP_ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psw_clear,
  input  logic                 restore_we,
  input  logic [DATA_W-1:0]    restore_data,
  input  logic                 int_accept,
  input  logic                 brk_exec,
  input  logic                 op_ei,
  input  logic                 op_di,
  input  logic                 op_setg,
  input  logic                 op_clrg,
  input  logic                 op_clrv,
  input  logic                 bit_test,
  input  logic [DATA_W-1:0]    bit_mem,
  input  logic                 arith_en,
  input  logic                 arith_sub,
  input  logic                 arith_cin,
  input  logic [DATA_W-1:0]    arith_a,
  input  logic [DATA_W-1:0]    arith_b,
  input  logic                 data_en,
  input  logic [DATA_W-1:0]    data_val,
  input  logic                 carry_we,
  input  logic                 carry_val,
  input  logic [DATA_W-1:0]    dp_offset,
  output logic [DP_ADDR_W-1:0] dp_addr,
  output logic [DATA_W-1:0]    psw,
  output logic                 flag_n,
  output logic                 flag_v,
  output logic                 flag_g,
  output logic                 flag_b,
  output logic                 flag_h,
  output logic                 flag_i,
  output logic                 flag_z,
  output logic                 flag_c
);
  psw_t         psw_q;
  psw_t         psw_d;
  logic         psw_en;
  arith_flags_t ar_flags;

  psw_arith_flags u_arith (
    .sub   (arith_sub),
    .cin   (arith_cin),
    .a     (arith_a),
    .b     (arith_b),
    .flags (ar_flags)
  );

  psw_flag_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur          (psw_q),
    .psw_clear    (psw_clear),
    .restore_we   (restore_we),
    .restore_data (restore_data),
    .int_accept   (int_accept),
    .brk_exec     (brk_exec),
    .op_ei        (op_ei),
    .op_di        (op_di),
    .op_setg      (op_setg),
    .op_clrg      (op_clrg),
    .op_clrv      (op_clrv),
    .bit_test     (bit_test),
    .bit_mem      (bit_mem),
    .arith_en     (arith_en),
    .ar           (ar_flags),
    .data_en      (data_en),
    .data_val     (data_val),
    .carry_we     (carry_we),
    .carry_val    (carry_val),
    .nxt          (psw_d),
    .upd          (psw_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q <= '0;
    end else if (psw_en) begin
      psw_q <= psw_d;
    end
  end

  psw_page_map #(
    .ADDR_W (DP_ADDR_W),
    .OFF_W  (DATA_W)
  ) u_page (
    .page_sel (psw_q.g),
    .offset   (dp_offset),
    .addr     (dp_addr)
  );

  always_comb begin
    psw    = psw_q;
    flag_n = psw_q.n;
    flag_v = psw_q.v;
    flag_g = psw_q.g;
    flag_b = psw_q.b;
    flag_h = psw_q.h;
    flag_i = psw_q.i;
    flag_z = psw_q.z;
    flag_c = psw_q.c;
  end

  // R1: a clear leaves an all-zero byte
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    psw_clear |=> (psw == '0));

  // R10: restore loads the whole byte
  a_r10_restore_load: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_we && !psw_clear) |=> (psw == $past(restore_data)));

  // R7: bit test copies the memory sign bit into N
  a_r7_bit_test_n: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_test && !psw_clear && !restore_we) |=> (flag_n == $past(bit_mem[DATA_W-1])));

  // R9: once set, B holds unless cleared or restored
  a_r9_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b && !psw_clear && !restore_we) |=> flag_b);

  // R11: with no strobe the byte keeps its value
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(psw_clear | restore_we | int_accept | brk_exec | op_ei | op_di | op_setg |
      op_clrg | op_clrv | bit_test | arith_en | data_en | carry_we) |=> $stable(psw));
endmodule

// File: tb/cpu_status_word_bench.sv
module cpu_status_word_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        psw_clear, restore_we, int_accept, brk_exec;
  logic        op_ei, op_di, op_setg, op_clrg, op_clrv, bit_test;
  logic [7:0]  restore_data, bit_mem, arith_a, arith_b, data_val, dp_offset;
  logic        arith_en, arith_sub, arith_cin, data_en, carry_we, carry_val;
  logic [15:0] dp_addr;
  logic [7:0]  psw;
  logic        flag_n, flag_v, flag_g, flag_b, flag_h, flag_i, flag_z, flag_c;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  cpu_status_word u_cpu_status_word (
    .clk(clk), .rst_n(rst_n), .psw_clear(psw_clear), .restore_we(restore_we),
    .restore_data(restore_data), .int_accept(int_accept), .brk_exec(brk_exec),
    .op_ei(op_ei), .op_di(op_di), .op_setg(op_setg), .op_clrg(op_clrg),
    .op_clrv(op_clrv), .bit_test(bit_test), .bit_mem(bit_mem),
    .arith_en(arith_en), .arith_sub(arith_sub), .arith_cin(arith_cin),
    .arith_a(arith_a), .arith_b(arith_b), .data_en(data_en), .data_val(data_val),
    .carry_we(carry_we), .carry_val(carry_val), .dp_offset(dp_offset),
    .dp_addr(dp_addr), .psw(psw), .flag_n(flag_n), .flag_v(flag_v),
    .flag_g(flag_g), .flag_b(flag_b), .flag_h(flag_h), .flag_i(flag_i),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {sub, cin, a, b, expected psw}; psw bits N=7 V=6 H=3 Z=1 C=0
  localparam logic [25:0] VEC [0:9] = '{
    {1'b0, 1'b0, 8'h7F, 8'h01, 8'hC8},  // signed overflow into 0x80, half carry
    {1'b0, 1'b0, 8'h0F, 8'h01, 8'h08},  // half carry only
    {1'b0, 1'b0, 8'h80, 8'h80, 8'h43},  // negative overflow, carry, zero
    {1'b0, 1'b1, 8'hFF, 8'h00, 8'h0B},  // carry in wraps to zero
    {1'b0, 1'b0, 8'h12, 8'h34, 8'h00},  // plain add
    {1'b1, 1'b1, 8'h80, 8'h01, 8'h41},  // 0x80-1 overflows
    {1'b1, 1'b1, 8'h7F, 8'hFF, 8'hC8},  // 127-(-1) overflows, borrow
    {1'b1, 1'b1, 8'h05, 8'h05, 8'h0B},  // equal operands
    {1'b1, 1'b1, 8'h10, 8'h01, 8'h01},  // borrow from bit 4
    {1'b1, 1'b1, 8'h00, 8'h01, 8'h80}   // unsigned underflow
  };

  task automatic idle_inputs();
    psw_clear = 0; restore_we = 0; restore_data = 0; int_accept = 0; brk_exec = 0;
    op_ei = 0; op_di = 0; op_setg = 0; op_clrg = 0; op_clrv = 0;
    bit_test = 0; bit_mem = 0; arith_en = 0; arith_sub = 0; arith_cin = 0;
    arith_a = 0; arith_b = 0; data_en = 0; data_val = 0; carry_we = 0; carry_val = 0;
  endtask

  // Inputs already set at a falling edge: take one rising edge, release, sample at next falling edge.
  task automatic step();
    @(posedge clk);
    #1 idle_inputs();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_psw();
    psw_clear = 1; step();
  endtask

  initial begin
    idle_inputs();
    dp_offset = 8'h35;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset value", {8'h0, psw}, 16'h0000);
    rst_n = 1;
    @(negedge clk);

    // R2 / R3 / R4: arithmetic vectors
    for (int k = 0; k < 10; k++) begin
      clear_psw();
      arith_en = 1; arith_sub = VEC[k][25]; arith_cin = VEC[k][24];
      arith_a = VEC[k][23:16]; arith_b = VEC[k][15:8];
      step();
      check($sformatf("R2/R3/R4 vector %0d", k), {8'h0, psw}, {8'h0, VEC[k][7:0]});
    end

    // R5: interrupt enable
    clear_psw();
    op_ei = 1; step();
    check("R5 ei sets I", {8'h0, psw}, 16'h0004);
    op_ei = 1; int_accept = 1; step();
    check("R5 accept beats ei", {8'h0, psw}, 16'h0000);
    op_ei = 1; step();
    op_ei = 1; op_di = 1; step();
    check("R5 di beats ei", {8'h0, psw}, 16'h0000);

    // R6: clear of H and V against a same-cycle overflow
    clear_psw();
    arith_en = 1; arith_a = 8'h7F; arith_b = 8'h01; step();
    arith_en = 1; arith_a = 8'h7F; arith_b = 8'h01; op_clrv = 1; step();
    check("R6 clrv beats arith", {8'h0, psw}, 16'h0080);

    // R7: bit test copies bits 7/6 only
    clear_psw();
    carry_we = 1; carry_val = 1; step();
    bit_test = 1; bit_mem = 8'h40; step();
    check("R7 bit test 0x40", {8'h0, psw}, 16'h0041);
    // R12: bit test beats arith on N, V; arith supplies H
    clear_psw();
    bit_test = 1; bit_mem = 8'h80; arith_en = 1; arith_a = 8'h7F; arith_b = 8'h01; step();
    check("R12 bit test over arith", {8'h0, psw}, 16'h0088);

    // R8: direct page select
    clear_psw();
    check("R8 page 0 address", dp_addr, 16'h0035);
    op_setg = 1; step();
    check("R8 setg psw", {8'h0, psw}, 16'h0020);
    check("R8 page 1 address", dp_addr, 16'h0135);
    dp_offset = 8'hFF; #1;
    check("R8 page 1 top", dp_addr, 16'h01FF);
    op_setg = 1; op_clrg = 1; step();
    check("R8 clrg beats setg", dp_addr, 16'h00FF);

    // R9: break marker persists
    clear_psw();
    brk_exec = 1; step();
    check("R9 brk sets B", {8'h0, psw}, 16'h0010);
    arith_en = 1; arith_a = 8'h01; arith_b = 8'h02; op_clrv = 1; step();
    check("R9 B survives", {8'h0, psw}, 16'h0010);

    // R10: restore priority
    restore_we = 1; restore_data = 8'hA5; op_ei = 1; brk_exec = 1; arith_en = 1;
    arith_a = 8'h7F; arith_b = 8'h01; int_accept = 1; step();
    check("R10 restore wins", {8'h0, psw}, 16'h00A5);
    psw_clear = 1; restore_we = 1; restore_data = 8'hFF; step();
    check("R10/R1 clear beats restore", {8'h0, psw}, 16'h0000);

    // R11: transfer and carry strobes, idle
    carry_we = 1; carry_val = 1; step();
    check("R11 carry write", {8'h0, psw}, 16'h0001);
    data_en = 1; data_val = 8'h00; step();
    check("R11 transfer zero", {8'h0, psw}, 16'h0003);
    data_en = 1; data_val = 8'h80; step();
    check("R11 transfer negative", {8'h0, psw}, 16'h0081);
    step();
    check("R11 idle holds", {8'h0, psw}, 16'h0081);

    // R12: arith beats transfer and carry write
    arith_en = 1; arith_a = 8'h05; arith_b = 8'h05; data_en = 1; data_val = 8'h80;
    carry_we = 1; carry_val = 1; step();
    check("R12 arith over transfer", {8'h0, psw}, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule